// File: doc/BRIEF.md
# Line Transceiver Start-Up Sequencer

This block brings a line transceiver into service once its supplies are stable. It first walks a configuration table that is fixed at elaboration time. Each table entry holds a register address and a data byte. The table covers every register of the transceiver, test registers included, because none of them holds a known value at power-up. The sequencer writes one entry per cycle through a simple parallel write port.

With every register loaded, the sequencer pulses the line-interface reset control and then waits out a long recovery interval, about 40 ms on silicon. The interval is a cycle count, so a simulation can set it much shorter. If elastic stores are in use, the sequencer then waits until both system clocks report stable and pulses the elastic-store reset control. If elastic stores are strapped off, it skips that whole step. A done flag marks the end of the sequence.

Reset is synchronous and active low. The sequence starts over from the table whenever reset is released.

Top module: `xcvr_boot_seq`

## Requirements
- R1: After the first clock edge that samples `rst_n` high, `wr_en` is high for exactly N_REGS consecutive cycles. In the k-th of these cycles, `wr_addr` carries the upper ADDR_W bits of table entry k (entry k is `CFG_TABLE[k]`, so k = 0 comes first) and `wr_data` carries the lower DATA_W bits.
- R2: `li_rst` first rises in the cycle right after the last write. No reset control and no `done` is high while writes are in progress or while `rst_n` is low.
- R3: `li_rst` stays high for exactly PULSE_CYCLES cycles (at least one) and then returns low.
- R4: After `li_rst` falls, all outputs stay low for exactly RECOVERY_CYCLES cycles before the next step begins.
- R5: If `es_enable` is high when recovery ends, the sequencer holds until a clock edge samples both `rx_clk_ok` and `tx_clk_ok` high. `es_rst` rises in the cycle after that edge. One flag high on its own does not advance the sequence.
- R6: `es_rst` stays high for exactly PULSE_CYCLES cycles. `done` rises as `es_rst` falls.
- R7: If `es_enable` is low when recovery ends, `es_rst` never rises and `done` rises in the cycle after recovery, whatever the clock flags are doing.
- R8: Once `done` is high, it stays high until a clock edge samples `rst_n` low. After that edge, `done` is low and the sequence restarts from table entry 0.
- R9: At most one of `wr_en`, `li_rst`, `es_rst` and `done` is high in any cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| rx_clk_ok | input | 1 | Receive system clock reported stable |
| tx_clk_ok | input | 1 | Transmit system clock reported stable |
| es_enable | input | 1 | Strap: elastic stores in use |
| wr_en | output | 1 | Write strobe of the configuration port |
| wr_addr | output | ADDR_W | Register address being written |
| wr_data | output | DATA_W | Register data being written |
| li_rst | output | 1 | Line-interface reset control |
| es_rst | output | 1 | Elastic-store reset control |
| done | output | 1 | Sequence complete |

## Verification
Three runs drive the sequence with different patterns.

- **Clocks stable late, stores enabled.** Both clocks start unstable and the receive flag rises alone first. This run shows that the sequencer waits on both flags together and not on either one.
- **Stores strapped off.** The clock flags stay low and then toggle. This run shows the skip path, as distinct from a stall.
- **Clocks stable early, reset mid-run.** Both clocks are already stable, and a reset lands in the middle of recovery. This run shows that the sequence restarts from table entry 0 and that the pulse and wait lengths are counted afresh.

A cycle-level reference model is compared against every output on every clock, so an off-by-one in any interval shows up directly.

// File: rtl/xbs_pkg.sv
package xbs_pkg;
   typedef enum logic [2:0] {
      SQ_IDLE,
      SQ_CFG,
      SQ_LI_PULSE,
      SQ_LI_WAIT,
      SQ_CLK_WAIT,
      SQ_ES_PULSE,
      SQ_DONE
   } seq_state_t;
endpackage

// File: rtl/xbs_cfg_walker.sv
// Steps through the configuration table, one entry per active cycle.
module xbs_cfg_walker #(
   parameter int unsigned N_REGS  = 4,
   parameter int unsigned ENTRY_W = 16,
   parameter logic [N_REGS-1:0][ENTRY_W-1:0] TABLE = '0
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               active,
   output logic [ENTRY_W-1:0] entry,
   output logic               last
);
   localparam int unsigned IDX_W = (N_REGS > 1) ? $clog2(N_REGS) : 1;
   localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(N_REGS - 1);

   logic [IDX_W-1:0] idx;

   always_ff @(posedge clk) begin
      if (!rst_n)
         idx <= '0;
      else if (active && idx != LAST_IDX)
         idx <= idx + 1'b1;
   end

   assign entry = TABLE[idx];
   assign last  = (idx == LAST_IDX);
endmodule

// File: rtl/xbs_timer.sv
// Down counter shared by the pulse and recovery intervals.
module xbs_timer #(
   parameter int unsigned W = 8
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         load,
   input  logic [W-1:0] load_val,
   output logic         zero
);
   logic [W-1:0] cnt;

   always_ff @(posedge clk) begin
      if (!rst_n)
         cnt <= '0;
      else if (load)
         cnt <= load_val;
      else if (cnt != '0)
         cnt <= cnt - 1'b1;
   end

   assign zero = (cnt == '0);
endmodule

// File: rtl/xcvr_boot_seq.sv
module xcvr_boot_seq #(
   parameter int unsigned ADDR_W       = 8,
   parameter int unsigned DATA_W       = 8,
   parameter int unsigned N_REGS       = 4,
   parameter logic [N_REGS-1:0][ADDR_W+DATA_W-1:0] CFG_TABLE =
      {16'h7F00, 16'h3512, 16'h1A80, 16'h0004},
   parameter int unsigned CLK_KHZ      = 200000,
   parameter int unsigned RECOVERY_MS  = 40,
   parameter int unsigned RECOVERY_CYCLES = CLK_KHZ * RECOVERY_MS,
   parameter int unsigned PULSE_CYCLES = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              rx_clk_ok,
   input  logic              tx_clk_ok,
   input  logic              es_enable,
   output logic              wr_en,
   output logic [ADDR_W-1:0] wr_addr,
   output logic [DATA_W-1:0] wr_data,
   output logic              li_rst,
   output logic              es_rst,
   output logic              done
);
   import xbs_pkg::*;

   localparam int unsigned ENTRY_W = ADDR_W + DATA_W;
   localparam int unsigned TMR_MAX = (RECOVERY_CYCLES > PULSE_CYCLES) ?
                                     RECOVERY_CYCLES : PULSE_CYCLES;
   localparam int unsigned TMR_W   = $clog2(TMR_MAX + 1);
   localparam logic [TMR_W-1:0] PULSE_LOAD = TMR_W'(PULSE_CYCLES - 1);
   localparam logic [TMR_W-1:0] WAIT_LOAD  = TMR_W'(RECOVERY_CYCLES - 1);

   generate
      if (N_REGS < 1)
         $error("xcvr_boot_seq: N_REGS must be at least 1");
      if (PULSE_CYCLES < 1)
         $error("xcvr_boot_seq: PULSE_CYCLES must be at least 1");
      if (RECOVERY_CYCLES < 1)
         $error("xcvr_boot_seq: RECOVERY_CYCLES must be at least 1");
      if (ADDR_W < 1 || DATA_W < 1)
         $error("xcvr_boot_seq: port widths must be non-zero");
   endgenerate

   seq_state_t         state, state_nxt;
   logic               tm_load, tm_zero;
   logic [TMR_W-1:0]   tm_val;
   logic [ENTRY_W-1:0] entry;
   logic               entry_last;

   xbs_cfg_walker #(
      .N_REGS (N_REGS),
      .ENTRY_W(ENTRY_W),
      .TABLE  (CFG_TABLE)
   ) u_walker (
      .clk   (clk),
      .rst_n (rst_n),
      .active(state == SQ_CFG),
      .entry (entry),
      .last  (entry_last)
   );

   xbs_timer #(.W(TMR_W)) u_timer (
      .clk     (clk),
      .rst_n   (rst_n),
      .load    (tm_load),
      .load_val(tm_val),
      .zero    (tm_zero)
   );

   always_comb begin
      state_nxt = state;
      tm_load   = 1'b0;
      tm_val    = '0;
      unique case (state)
         SQ_IDLE: state_nxt = SQ_CFG;
         SQ_CFG: if (entry_last) begin
            state_nxt = SQ_LI_PULSE;
            tm_load   = 1'b1;
            tm_val    = PULSE_LOAD;
         end
         SQ_LI_PULSE: if (tm_zero) begin
            state_nxt = SQ_LI_WAIT;
            tm_load   = 1'b1;
            tm_val    = WAIT_LOAD;
         end
         SQ_LI_WAIT: if (tm_zero)
            state_nxt = es_enable ? SQ_CLK_WAIT : SQ_DONE;
         SQ_CLK_WAIT: if (rx_clk_ok && tx_clk_ok) begin
            state_nxt = SQ_ES_PULSE;
            tm_load   = 1'b1;
            tm_val    = PULSE_LOAD;
         end
         SQ_ES_PULSE: if (tm_zero) state_nxt = SQ_DONE;
         SQ_DONE: state_nxt = SQ_DONE;
         default: state_nxt = SQ_IDLE;
      endcase
   end

   always_ff @(posedge clk) begin
      if (!rst_n)
         state <= SQ_IDLE;
      else
         state <= state_nxt;
   end

   assign wr_en   = (state == SQ_CFG);
   assign wr_addr = entry[ENTRY_W-1 -: ADDR_W];
   assign wr_data = entry[DATA_W-1:0];
   assign li_rst  = (state == SQ_LI_PULSE);
   assign es_rst  = (state == SQ_ES_PULSE);
   assign done    = (state == SQ_DONE);
endmodule

// File: rtl/xbs_chk.sv
module xbs_chk #(
   parameter int unsigned PULSE_CYCLES = 4
) (
   input logic clk,
   input logic rst_n,
   input logic rx_clk_ok,
   input logic tx_clk_ok,
   input logic wr_en,
   input logic li_rst,
   input logic es_rst,
   input logic done
);
   AST_ONE_ACTIVE: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({wr_en, li_rst, es_rst, done}));                     // R9

   AST_LI_AFTER_CFG: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(li_rst) |-> $past(wr_en));                              // R2

   AST_LI_MIN_WIDTH: assert property (@(posedge clk) disable iff (!rst_n)
      ($rose(li_rst) && PULSE_CYCLES > 1) |=> li_rst);              // R3

   AST_ES_CLK_GATE: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(es_rst) |-> $past(rx_clk_ok && tx_clk_ok));             // R5

   AST_DONE_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> done);                                               // R8

   AST_DONE_ENTRY: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(done) |-> !$past(wr_en) && !$past(li_rst));             // R6
endmodule

bind xcvr_boot_seq xbs_chk #(.PULSE_CYCLES(PULSE_CYCLES)) u_xbs_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .rx_clk_ok(rx_clk_ok),
   .tx_clk_ok(tx_clk_ok),
   .wr_en    (wr_en),
   .li_rst   (li_rst),
   .es_rst   (es_rst),
   .done     (done)
);

// File: tb/tb_xcvr_boot_seq.sv
module tb_xcvr_boot_seq;
   localparam int NREG  = 5;
   localparam int PULSE = 3;
   localparam int REC   = 20;
   localparam logic [NREG-1:0][15:0] TB_TABLE =
      {16'hF03C, 16'hC401, 16'h80FF, 16'h215A, 16'h00A5};

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic rx_clk_ok = 1'b0, tx_clk_ok = 1'b0, es_enable = 1'b1;
   logic wr_en, li_rst, es_rst, done;
   logic [7:0] wr_addr, wr_data;

   int checks = 0, errors = 0, cyc = 0;
   int mph = 6, mcnt = 0;
   int li_hi = 0, es_hi = 0, wr_hi = 0;

   always #2.5 clk = ~clk;

   xcvr_boot_seq #(
      .ADDR_W(8), .DATA_W(8), .N_REGS(NREG), .CFG_TABLE(TB_TABLE),
      .RECOVERY_CYCLES(REC), .PULSE_CYCLES(PULSE)
   ) dut (
      .clk(clk), .rst_n(rst_n), .rx_clk_ok(rx_clk_ok), .tx_clk_ok(tx_clk_ok),
      .es_enable(es_enable), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
      .li_rst(li_rst), .es_rst(es_rst), .done(done)
   );

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual=%0h expected=%0h (cycle %0d)", req, act, exp, cyc);
      end
   endtask

   // reference model: phase 6 idle, 0 writes, 1 li pulse, 2 recovery,
   // 3 clock wait, 4 es pulse, 5 done
   always @(posedge clk) begin
      cyc++;
      if (rst_n) begin
         li_hi += int'(li_rst);
         es_hi += int'(es_rst);
         wr_hi += int'(wr_en);
      end
      if (!rst_n) begin mph = 6; mcnt = 0; end
      else case (mph)
         6: begin mph = 0; mcnt = 0; end
         0: if (mcnt == NREG - 1) begin mph = 1; mcnt = 0; end else mcnt++;
         1: if (mcnt == PULSE - 1) begin mph = 2; mcnt = 0; end else mcnt++;
         2: if (mcnt == REC - 1) begin mph = es_enable ? 3 : 5; mcnt = 0; end
            else mcnt++;
         3: if (rx_clk_ok && tx_clk_ok) begin mph = 4; mcnt = 0; end
         4: if (mcnt == PULSE - 1) begin mph = 5; mcnt = 0; end else mcnt++;
         default: mph = 5;
      endcase
   end

   always @(negedge clk) begin
      string tag;
      case (mph)
         0: tag = "R1"; 1: tag = "R3"; 2: tag = "R4"; 3: tag = "R5";
         4: tag = "R6"; 5: tag = "R8"; default: tag = "R2";
      endcase
      if (!es_enable && mph == 5) tag = "R7";
      chk(wr_en == (mph == 0), {tag, " wr_en"}, wr_en, mph == 0);
      chk(li_rst == (mph == 1), {tag, " li_rst"}, li_rst, mph == 1);
      chk(es_rst == (mph == 4), {tag, " es_rst"}, es_rst, mph == 4);
      chk(done == (mph == 5), {tag, " done"}, done, mph == 5);
      if (mph == 0) begin
         chk(wr_addr == TB_TABLE[mcnt][15:8], "R1 wr_addr", wr_addr, TB_TABLE[mcnt][15:8]);
         chk(wr_data == TB_TABLE[mcnt][7:0], "R1 wr_data", wr_data, TB_TABLE[mcnt][7:0]);
      end
      chk(($countones({wr_en, li_rst, es_rst, done}) <= 1), "R9 exclusive",
          {wr_en, li_rst, es_rst, done}, 0);
   end

   task automatic cycles(input int n);
      for (int i = 0; i < n; i++) @(negedge clk);
   endtask

   task automatic start_run(input logic en);
      @(negedge clk);
      rst_n = 1'b0;
      es_enable = en;
      cycles(2);
      chk(!wr_en && !li_rst && !es_rst && !done, "R2 reset outputs",
          {wr_en, li_rst, es_rst, done}, 0);
      li_hi = 0; es_hi = 0; wr_hi = 0;
      rst_n = 1'b1;
   endtask

   initial begin
      // run 1: stores enabled, clocks become stable late, rx alone first
      start_run(1'b1);
      cycles(NREG + PULSE + REC + 8);
      chk(!es_rst && !done, "R5 stall without clocks", {es_rst, done}, 0);
      rx_clk_ok = 1'b1;
      cycles(6);
      chk(!es_rst && !done, "R5 stall rx only", {es_rst, done}, 0);
      tx_clk_ok = 1'b1;
      cycles(1);
      chk(es_rst == 1'b1, "R5 es_rst after both stable", es_rst, 1);
      cycles(PULSE + 10);
      chk(done == 1'b1, "R8 done held", done, 1);
      chk(wr_hi == NREG, "R1 write count", wr_hi, NREG);
      chk(li_hi == PULSE, "R3 li pulse width", li_hi, PULSE);
      chk(es_hi == PULSE, "R6 es pulse width", es_hi, PULSE);

      // run 2: stores strapped off, clock flags ignored
      rx_clk_ok = 1'b0; tx_clk_ok = 1'b0;
      start_run(1'b0);
      cycles(1);
      chk(wr_en == 1'b1, "R8 restart after done", wr_en, 1);
      cycles(NREG + PULSE + REC + 4);
      rx_clk_ok = 1'b1; tx_clk_ok = 1'b1;
      cycles(4);
      rx_clk_ok = 1'b0;
      cycles(4);
      chk(done == 1'b1, "R7 done without es step", done, 1);
      chk(es_hi == 0, "R7 no es pulse", es_hi, 0);
      chk(li_hi == PULSE, "R3 li pulse width run2", li_hi, PULSE);

      // run 3: clocks already stable, reset in mid-recovery, then full run
      rx_clk_ok = 1'b1; tx_clk_ok = 1'b1;
      start_run(1'b1);
      cycles(NREG + PULSE + 5);
      start_run(1'b1);
      cycles(1);
      chk(wr_addr == TB_TABLE[0][15:8], "R8 restart at entry 0", wr_addr, TB_TABLE[0][15:8]);
      cycles(NREG + PULSE + REC + PULSE + 6);
      chk(done == 1'b1, "R6 done after es pulse", done, 1);
      chk(es_hi == PULSE, "R6 es pulse width run3", es_hi, PULSE);
      chk(wr_hi == NREG, "R1 write count run3", wr_hi, NREG);

      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      #50000;
      checks++; errors++;
      $display("FAIL watchdog expired at cycle %0d actual=running expected=finished", cyc);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule